// File: doc/BRIEF.md
# Security-Banked Distributor Control Register

This block is the top-level control register of an interrupt distributor. It holds two forwarding enables: one for the secure group (group 0) and one for the non-secure group (group 1). Each enable gates that group's pending-interrupt input into a forwarded output, which goes on to the CPU interfaces. Software reaches the register through a byte-wide port that carries an offset, a write strobe, write data, read data and a qualifier that marks the access as non-secure.

The control byte at offset 0 shows a different layout to different callers. Two static inputs select this view: one says whether security extensions are present, the other selects architecture revision 2 instead of revision 1.

- **Full view.** A revision 2 part without security extensions, or any secure access when security extensions are present, sees both enables.
- **Non-secure view.** A non-secure access on a part with security extensions sees only the group 1 enable, placed in bit 0.
- **Legacy view.** A revision 1 part without security extensions has a single distribution enable. This enable gates both groups.

Offset 4 returns the size of the controller.

Top module: `dist_ctrl_bank`

## Requirements
- R1: After reset, both group enables are 0, a read at offset 0 returns 0x00, and neither forwarded output is asserted.
- R2: In the full view (revision 2 without security extensions, or a secure access with security extensions), offset 0 bit 0 reads and writes the group 0 enable and bit 1 reads and writes the group 1 enable.
- R3: With security extensions present, a non-secure access at offset 0 reads and writes the group 1 enable in bit 0. Such an access never changes the group 0 enable, and its read returns 0 in bits 7:1.
- R4: In the legacy view (revision 1 without security extensions), offset 0 bit 0 is a single enable, which is presented on both group enable outputs. Bits 7:1 are ignored on write and read as 0. The access qualifier has no effect.
- R5: With security extensions on a revision 1 part, a secure access still reads and writes the group 1 enable in bit 1.
- R6: Each stored enable is exactly one bit. Writing 0x02 in the full view reads back 0x02, and writing 0xFF reads back 0x03.
- R7: Writes to offsets 1, 2 and 3 change no enable, and reads at those offsets return 0x00.
- R8: A read at offset 4 returns NUM_IRQ/32 − 1 in bits 4:0, with the upper bits 0. The default NUM_IRQ of 96 gives 0x02.
- R9: A group's forwarded output is high exactly when that group's effective enable is 1 and its pending input is high.
- R10: Read data follows the offset and access qualifier in the same cycle. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sec_ext | input | 1 | Security extensions present (static) |
| cfg_rev2 | input | 1 | 1 = revision 2, 0 = revision 1 (static) |
| reg_ofs | input | 8 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_ns | input | 1 | Access is non-secure |
| reg_rdata | output | 8 | Read data for reg_ofs |
| grp0_en | output | 1 | Effective group 0 enable |
| grp1_en | output | 1 | Effective group 1 enable |
| pend_g0 | input | 1 | Group 0 interrupt pending |
| pend_g1 | input | 1 | Group 1 interrupt pending |
| fwd_g0 | output | 1 | Group 0 interrupt forwarded |
| fwd_g1 | output | 1 | Group 1 interrupt forwarded |

## Verification
A wrong stored enable shows at the ports in the cycle after the write that caused it, in three places: the enable outputs, the forwarded outputs, and the read data of the view that exposes the bit. A view-decode error differs in kind. It changes only the read data, or it steers the write into the wrong group. A write steered this way shows only when that group is read back through another view, so the vectors alternate secure and non-secure readers. A normalisation error is visible only as a bit at the wrong position, so the vectors write each bit alone and read the whole byte.

// File: rtl/dctl_pkg.sv
// Package: shared view type and offsets for the distributor control register.
// Assumes byte offsets; the control byte and type byte locations are fixed.
package dctl_pkg;
    typedef enum logic [1:0] {
        VIEW_LEGACY = 2'd0,
        VIEW_FULL   = 2'd1,
        VIEW_NS     = 2'd2
    } view_e;

    localparam int NGRP     = 2;
    localparam int OFS_CTRL = 0;
    localparam int OFS_TYPE = 4;
endpackage

// File: rtl/dctl_view_decode.sv
// Module: selects which layout the current access sees at the control byte.
// Assumes configuration inputs are static between resets.
module dctl_view_decode
    import dctl_pkg::*;
(
    input  logic  sec_ext,
    input  logic  rev2,
    input  logic  ns,
    output view_e view
);
    // Purpose: map security configuration and caller state to a view.
    always_comb begin
        if (sec_ext) begin
            view = ns ? VIEW_NS : VIEW_FULL;
        end else if (rev2) begin
            view = VIEW_FULL;
        end else begin
            view = VIEW_LEGACY;
        end
    end
endmodule

// File: rtl/dctl_enable_regs.sv
// Module: holds the two one-bit group enables and applies control-byte writes.
// Assumes the caller has already decoded the view; only offset OFS_CTRL writes.
// In the legacy view the group 0 flop stores the single distribution enable.
module dctl_enable_regs
    import dctl_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  view_e             view,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [NGRP-1:0]   en_q
);
    logic hit;

    // Purpose: qualify the write strobe with the control-byte offset.
    always_comb hit = wr && (ofs == OFS_W'(OFS_CTRL));

    // Purpose: update the stored enables, one bit each, per the view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit) begin
            unique case (view)
                VIEW_FULL: begin
                    en_q[0] <= wdata[0];
                    en_q[1] <= wdata[1];
                end
                VIEW_NS:     en_q[1] <= wdata[0];
                VIEW_LEGACY: en_q[0] <= wdata[0];
                default:     en_q    <= en_q;
            endcase
        end
    end
endmodule

// File: rtl/dctl_fwd_gate.sv
// Module: gates each group's pending input with that group's effective enable.
// Assumes enables are already resolved for the legacy view.
module dctl_fwd_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] pend,
    output logic [N-1:0] fwd
);
    for (genvar g = 0; g < N; g++) begin : g_grp
        // Purpose: forward group g only while it is enabled.
        always_comb fwd[g] = en[g] & pend[g];
    end
endmodule

// File: rtl/dist_ctrl_bank.sv
// Module: top of the security-banked distributor control register.
// Provides the control byte (view-dependent), the controller type byte, the
// effective group enables and the gated forward outputs.
// Assumes cfg_* are static between resets and NUM_IRQ is a multiple of 32.
module dist_ctrl_bank
    import dctl_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int OFS_W   = 8,
    parameter int DATA_W  = 8,
    parameter int TYPE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sec_ext,
    input  logic              cfg_rev2,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ns,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              grp0_en,
    output logic              grp1_en,
    input  logic              pend_g0,
    input  logic              pend_g1,
    output logic              fwd_g0,
    output logic              fwd_g1
);
    localparam int                TYPE_INT = NUM_IRQ / 32 - 1;
    localparam logic [TYPE_W-1:0] TYPE_VAL = TYPE_W'(TYPE_INT);

    view_e           view;
    view_e           cfg_view;
    logic [NGRP-1:0] en_q;
    logic [NGRP-1:0] en_eff;
    logic [NGRP-1:0] fwd;

    dctl_view_decode u_view (
        .sec_ext (cfg_sec_ext),
        .rev2    (cfg_rev2),
        .ns      (reg_ns),
        .view    (view)
    );

    // Legacy detection for the outputs ignores the caller's security state.
    dctl_view_decode u_cfg_view (
        .sec_ext (cfg_sec_ext),
        .rev2    (cfg_rev2),
        .ns      (1'b0),
        .view    (cfg_view)
    );

    dctl_enable_regs #(
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .view  (view),
        .wr    (reg_wr),
        .ofs   (reg_ofs),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    // Purpose: the single legacy enable drives both groups.
    always_comb begin
        if (cfg_view == VIEW_LEGACY) begin
            en_eff = {NGRP{en_q[0]}};
        end else begin
            en_eff = en_q;
        end
    end

    dctl_fwd_gate #(.N(NGRP)) u_gate (
        .en   (en_eff),
        .pend ({pend_g1, pend_g0}),
        .fwd  (fwd)
    );

    // Purpose: combinational read mux over the control and type bytes.
    always_comb begin
        reg_rdata = '0;
        if (reg_ofs == OFS_W'(OFS_CTRL)) begin
            unique case (view)
                VIEW_FULL:   reg_rdata[1:0] = en_q;
                VIEW_NS:     reg_rdata[0]   = en_q[1];
                VIEW_LEGACY: reg_rdata[0]   = en_q[0];
                default:     reg_rdata      = '0;
            endcase
        end else if (reg_ofs == OFS_W'(OFS_TYPE)) begin
            reg_rdata[TYPE_W-1:0] = TYPE_VAL;
        end
    end

    // Purpose: present the resolved enables and forwards on the ports.
    always_comb begin
        grp0_en = en_eff[0];
        grp1_en = en_eff[1];
        fwd_g0  = fwd[0];
        fwd_g1  = fwd[1];
    end
endmodule

// File: rtl/dctl_chk.sv
// Checker: port-level properties of dist_ctrl_bank, bound to every instance.
module dctl_chk #(
    parameter int NUM_IRQ = 96,
    parameter int OFS_W   = 8,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_sec_ext,
    input logic [OFS_W-1:0]  reg_ofs,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_ns,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              grp0_en,
    input logic              grp1_en,
    input logic              fwd_g0,
    input logic              fwd_g1
);
    localparam logic [DATA_W-1:0] TYPE_EXP = DATA_W'(NUM_IRQ / 32 - 1);

    // R2
    sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ofs == '0 && cfg_sec_ext && !reg_ns)
        |=> (grp0_en == $past(reg_wdata[0]) && grp1_en == $past(reg_wdata[1])));

    // R3
    ns_keeps_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ofs == '0 && cfg_sec_ext && reg_ns) |=> $stable(grp0_en));

    // R3
    ns_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ofs == '0 && cfg_sec_ext && reg_ns) |-> (reg_rdata[DATA_W-1:1] == '0));

    // R6
    ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ofs == '0) |-> (reg_rdata[DATA_W-1:2] == '0));

    // R7
    dead_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ofs >= OFS_W'(1) && reg_ofs <= OFS_W'(3))
        |=> ($stable(grp0_en) && $stable(grp1_en)));

    // R8
    type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ofs == OFS_W'(4)) |-> (reg_rdata == TYPE_EXP));

    // R9
    fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grp0_en |-> !fwd_g0) and (!grp1_en |-> !fwd_g1)));
endmodule

bind dist_ctrl_bank dctl_chk #(
    .NUM_IRQ (NUM_IRQ),
    .OFS_W   (OFS_W),
    .DATA_W  (DATA_W)
) u_dctl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sec_ext (cfg_sec_ext),
    .reg_ofs     (reg_ofs),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_ns      (reg_ns),
    .reg_rdata   (reg_rdata),
    .grp0_en     (grp0_en),
    .grp1_en     (grp1_en),
    .fwd_g0      (fwd_g0),
    .fwd_g1      (fwd_g1)
);

// File: tb/test_dist_ctrl_bank.sv
// Bench: vector table of write-then-read steps, then directed corner tests.
module test_dist_ctrl_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sec_ext = 1'b0;
    logic       cfg_rev2 = 1'b1;
    logic [7:0] reg_ofs = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_ns = 1'b0;
    logic [7:0] reg_rdata;
    logic       grp0_en, grp1_en;
    logic       pend_g0 = 1'b0;
    logic       pend_g1 = 1'b0;
    logic       fwd_g0, fwd_g1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dist_ctrl_bank i_dist_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .cfg_sec_ext(cfg_sec_ext), .cfg_rev2(cfg_rev2),
        .reg_ofs(reg_ofs), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_ns(reg_ns),
        .reg_rdata(reg_rdata), .grp0_en(grp0_en), .grp1_en(grp1_en),
        .pend_g0(pend_g0), .pend_g1(pend_g1), .fwd_g0(fwd_g0), .fwd_g1(fwd_g1)
    );

    typedef struct packed {
        logic       rst;
        logic       se;
        logic       r2;
        logic       wns;
        logic [7:0] wofs;
        logic [7:0] wdat;
        logic       rns;
        logic [7:0] exp_rd;
        logic       exp_e0;
        logic       exp_e1;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        // R2: revision 2, no security extensions
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 8'h01, 1'b0, 8'h01, 1'b1, 1'b0},
        // R6: bit 1 alone stays at bit 1
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'h02, 1'b0, 8'h02, 1'b0, 1'b1},
        // R6: all ones normalise to 0x03
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'hFF, 1'b0, 8'h03, 1'b1, 1'b1},
        // R7: offset 1 write ignored
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 8'h00, 1'b0, 8'h03, 1'b1, 1'b1},
        // R7: offset 3 write ignored
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 8'h00, 1'b0, 8'h03, 1'b1, 1'b1},
        // R5: security extensions, revision 1, secure write
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 8'h03, 1'b0, 8'h03, 1'b1, 1'b1},
        // R3: non-secure clear hits group 1 only
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'h00, 1'b0, 8'h01, 1'b1, 1'b0},
        // R3: upper bits of a non-secure write ignored
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'hFE, 1'b1, 8'h00, 1'b1, 1'b0},
        // R3: non-secure set of group 1
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'h01, 1'b1, 8'h01, 1'b1, 1'b1},
        // R5: secure clear of both
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},
        // R3: non-secure 0x03 sets only group 1
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'h03, 1'b0, 8'h02, 1'b0, 1'b1},
        // R2: security extensions, revision 2, secure write
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 8'h02, 1'b0, 8'h02, 1'b0, 1'b1},
        // R4: legacy, bit 1 ignored
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0},
        // R4: legacy enable drives both groups
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'h03, 1'b0, 8'h01, 1'b1, 1'b1},
        // R7: legacy, offset 2 write ignored
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'h00, 1'b0, 8'h01, 1'b1, 1'b1},
        // R4: qualifier has no effect in legacy
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic se, input logic r2);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_sec_ext = se;
        cfg_rev2 = r2;
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic ns, input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        reg_ns = ns;
        reg_ofs = ofs;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        pend_g0 = 1'b1;
        pend_g1 = 1'b1;
        do_reset(1'b0, 1'b1);

        // R1: reset state
        reg_ofs = 8'd0;
        reg_ns = 1'b0;
        #1;
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 enables", {6'b0, grp1_en, grp0_en}, 8'h00);
        check("R1 forwards", {6'b0, fwd_g1, fwd_g0}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rst) do_reset(VEC[i].se, VEC[i].r2);
            do_write(VEC[i].wns, VEC[i].wofs, VEC[i].wdat);
            reg_ns = VEC[i].rns;
            reg_ofs = 8'd0;
            #1;
            check($sformatf("vec%0d rdata", i), reg_rdata, VEC[i].exp_rd);
            check($sformatf("vec%0d enables", i), {6'b0, grp1_en, grp0_en},
                  {6'b0, VEC[i].exp_e1, VEC[i].exp_e0});
            // R9: both pending, so forwards follow the enables
            check($sformatf("R9 vec%0d fwd", i), {6'b0, fwd_g1, fwd_g0},
                  {6'b0, VEC[i].exp_e1, VEC[i].exp_e0});
        end

        // R8: type byte
        reg_ofs = 8'd4;
        #1;
        check("R8 type", reg_rdata, 8'h02);
        // R7: reserved bytes read 0
        reg_ofs = 8'd1;
        #1;
        check("R7 ofs1 read", reg_rdata, 8'h00);
        reg_ofs = 8'd3;
        #1;
        check("R7 ofs3 read", reg_rdata, 8'h00);

        // R9: pending patterns with only group 0 enabled
        do_reset(1'b0, 1'b1);
        do_write(1'b0, 8'd0, 8'h01);
        pend_g0 = 1'b1; pend_g1 = 1'b1;
        #1;
        check("R9 g0 only, both pend", {6'b0, fwd_g1, fwd_g0}, 8'h01);
        pend_g0 = 1'b0;
        #1;
        check("R9 g0 only, none active", {6'b0, fwd_g1, fwd_g0}, 8'h00);
        do_write(1'b0, 8'd0, 8'h02);
        pend_g0 = 1'b1; pend_g1 = 1'b0;
        #1;
        check("R9 g1 only, g0 pend", {6'b0, fwd_g1, fwd_g0}, 8'h00);
        pend_g1 = 1'b1;
        #1;
        check("R9 g1 only, g1 pend", {6'b0, fwd_g1, fwd_g0}, 8'h02);

        // R10: write visible only after the edge; read is combinational
        @(negedge clk);
        reg_ns = 1'b0; reg_ofs = 8'd0; reg_wdata = 8'h01; reg_wr = 1'b1;
        #1;
        check("R10 before edge", reg_rdata, 8'h02);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        check("R10 after edge", reg_rdata, 8'h01);

        // R1: reset clears enables set before it
        do_reset(1'b1, 1'b0);
        reg_ofs = 8'd0;
        reg_ns = 1'b0;
        #1;
        check("R1 second reset", {reg_rdata[5:0], grp1_en, grp0_en}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule